// File: doc/BRIEF.md
# Segmented Scan Clock Group Controller

This block drives the shift and capture clocking of a scan design in which each of `NCHAIN` scan chains is cut into `NSEG` equal segments. The segments are shifted in `NSEG` groups, one group at a time. This lowers the number of flops that toggle on any one shift edge. Which segment of each chain belongs to which group is held in a programmable map, so a group may combine segment 0 of one chain with segment 2 of another. A group does not have to line up segment indices across chains.

A start strobe begins one test vector. The block then steps through the groups in ascending group order. Each group gets scan-length / `NSEG` shift cycles. Only the segments of the active group have their clock enabled, and for every chain the scan-in and scan-out mux select points at that chain's segment in the active group. After the last group has shifted, the block lowers scan enable and enables every segment clock for two cycles: a launch pulse and then a capture pulse. A one-cycle done pulse follows. A start with an unusable map or a too-short scan length is refused and flagged.

Every clock enable passes through a stage that is transparent only while the base clock is low. An enable therefore never changes during a high phase, and no pulse is cut short.

Top module: `segclk_ctrl`

## Requirements
- R1: After reset, all segment clock enables are 0, `scan_en` is 1, `busy`, `done` and `map_err` are 0, and the map places segment s of every chain in group s.
- R2: An accepted start (sampled while idle) gives `NSEG` shift phases in group order 0, 1, …, `NSEG`-1. Each phase lasts floor(`scan_len`/`NSEG`) consecutive cycles, and the first phase begins in the cycle after the start.
- R3: In every shift cycle, exactly one segment per chain has its enable high: the segment that the map assigns to the active group. Enable bit `c*NSEG+s` belongs to segment s of chain c.
- R4: `scan_en` stays high through the last shift cycle. It is then low for exactly two cycles (launch, then capture), with every segment enable high in both, and then returns high.
- R5: A cycle with `cfg_we` high while idle sets the group of segment `cfg_seg` of chain `cfg_chain` to `cfg_grp`. Groupings that are not index-aligned are honoured. A write while busy, or one with a chain or segment index out of range, is ignored.
- R6: While busy, field c of `chain_sel` (bits `c*SW +: SW`) holds the index of chain c's segment in the active group. The active group is `NSEG`-1 during launch, capture and done.
- R7: Within one vector, each segment is enabled for exactly floor(L/`NSEG`) shift cycles, where L is `scan_len` sampled at the start. Each chain therefore shifts L cycles when L is a multiple of `NSEG`. Changes to `scan_len` during a run have no effect.
- R8: `busy` is high from the cycle after an accepted start through the done cycle. A start while busy is ignored.
- R9: `done` is high for exactly one cycle, in the cycle right after the capture cycle.
- R10: A start while idle is refused if some chain does not have exactly one segment in every group, or if `scan_len` < `NSEG`. A refused start leaves the block idle and sets `map_err`. The next accepted start clears it.
- R11: Segment enables change only while `clk` is low. The value at a rising edge holds until the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to apply one vector |
| scan_len | input | LEN_W | Chain length in shift cycles |
| cfg_we | input | 1 | Map write strobe |
| cfg_chain | input | CW | Chain index of the map write |
| cfg_seg | input | SW | Segment index of the map write |
| cfg_grp | input | SW | Group assigned by the map write |
| seg_clk_en | output | NCHAIN*NSEG | Per-segment gated clock enable |
| chain_sel | output | NCHAIN*SW | Per-chain segment mux select |
| scan_en | output | 1 | High in shift mode, low in launch/capture |
| busy | output | 1 | A vector is in progress |
| done | output | 1 | One-cycle pulse after capture |
| map_err | output | 1 | Last start request was refused |

## Verification
The bench aims at group boundaries:
- A counter reload that is off by one stretches or shortens a phase, which breaks the per-segment pulse totals.
- A design that drops `scan_en` one cycle early cuts short the last group.

It programs a grouping in which no two chains share a segment index, so that a design hard-wired to index-aligned groups would enable the wrong segments. It also tries:
- a duplicate-group map, and a length shorter than the segment count, each of which must be refused rather than run;
- a restart and a map write in the middle of a run, which must leave the run untouched;
- a `scan_len` change during a run.

Finally, it compares the enables just after each rising edge with their value in the preceding low phase. An enable that changes while the clock is high would appear as a truncated clock pulse.

// File: rtl/segclk_pkg.sv
package segclk_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_LAUNCH,
    SQ_CAPTURE,
    SQ_DONE
  } sq_state_t;

  // Shift cycles given to each group for a chain of the given length.
  function automatic int unsigned seg_len_of(input int unsigned total,
                                             input int unsigned nseg);
    return total / nseg;
  endfunction

endpackage

// File: rtl/segclk_map.sv
module segclk_map #(
  parameter int NCHAIN = 3,
  parameter int NSEG   = 3,
  parameter int SW     = 2,
  parameter int CW     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CW-1:0]               wr_chain,
  input  logic [SW-1:0]               wr_seg,
  input  logic [SW-1:0]               wr_grp,
  input  logic [SW-1:0]               act_grp,
  output logic [NCHAIN*NSEG*SW-1:0]   map_flat,
  output logic                        map_ok,
  output logic [NCHAIN*SW-1:0]        chain_sel
);
  localparam int ROW_W = NSEG * SW;

  logic [ROW_W-1:0] row_q [NCHAIN];
  logic [NCHAIN-1:0] chain_ok;

  // Map contents after reset: segment s goes to group s.
  function automatic logic [ROW_W-1:0] identity_row();
    logic [ROW_W-1:0] r;
    r = '0;
    for (int s = 0; s < NSEG; s++) r[s*SW +: SW] = SW'(s);
    return r;
  endfunction

  // True when every group holds exactly one segment of this chain.
  function automatic logic row_is_perm(input logic [ROW_W-1:0] row);
    int hits;
    for (int g = 0; g < NSEG; g++) begin
      hits = 0;
      for (int s = 0; s < NSEG; s++)
        if (row[s*SW +: SW] == SW'(g)) hits++;
      if (hits != 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Segment of this chain that sits in the given group; the lowest index wins.
  function automatic logic [SW-1:0] seg_in_grp(input logic [ROW_W-1:0] row,
                                               input logic [SW-1:0]    grp);
    logic [SW-1:0] r;
    r = '0;
    for (int s = NSEG - 1; s >= 0; s--)
      if (row[s*SW +: SW] == grp) r = SW'(s);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAIN; c++) row_q[c] <= identity_row();
    end else if (wr_en) begin
      for (int c = 0; c < NCHAIN; c++)
        for (int s = 0; s < NSEG; s++)
          if (wr_chain == CW'(c) && wr_seg == SW'(s))
            row_q[c][s*SW +: SW] <= wr_grp;
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    assign map_flat[c*ROW_W +: ROW_W] = row_q[c];
    assign chain_ok[c]                = row_is_perm(row_q[c]);
    assign chain_sel[c*SW +: SW]      = seg_in_grp(row_q[c], act_grp);
  end

  assign map_ok = &chain_ok;

endmodule

// File: rtl/segclk_seq.sv
module segclk_seq
  import segclk_pkg::*;
#(
  parameter int NSEG  = 3,
  parameter int SW    = 2,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] scan_len,
  input  logic             map_ok,
  output sq_state_t        st,
  output logic [SW-1:0]    act_grp,
  output logic             start_acc,
  output logic             start_rej,
  output logic             shift_end,
  output logic             map_err
);
  localparam logic [SW-1:0] LAST_GRP = SW'(NSEG - 1);

  sq_state_t        st_q;
  logic [SW-1:0]    grp_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] seg_len_q;
  logic [LEN_W-1:0] seg_len_in;
  logic             err_q;
  logic             len_ok;
  logic             idle;

  assign seg_len_in = LEN_W'(seg_len_of(int'(scan_len), NSEG));
  assign len_ok     = (seg_len_in != '0);
  assign idle       = (st_q == SQ_IDLE);
  assign start_acc  = start && idle && map_ok && len_ok;
  assign start_rej  = start && idle && !(map_ok && len_ok);
  assign shift_end  = (st_q == SQ_SHIFT) && (cnt_q == '0) && (grp_q == LAST_GRP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      grp_q     <= '0;
      cnt_q     <= '0;
      seg_len_q <= '0;
      err_q     <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_acc) begin
            st_q      <= SQ_SHIFT;
            grp_q     <= '0;
            cnt_q     <= seg_len_in - LEN_W'(1);
            seg_len_q <= seg_len_in;
            err_q     <= 1'b0;
          end else if (start_rej) begin
            err_q <= 1'b1;
          end
        end
        SQ_SHIFT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
          end else if (grp_q == LAST_GRP) begin
            st_q <= SQ_LAUNCH;
          end else begin
            grp_q <= grp_q + SW'(1);
            cnt_q <= seg_len_q - LEN_W'(1);
          end
        end
        SQ_LAUNCH:  st_q <= SQ_CAPTURE;
        SQ_CAPTURE: st_q <= SQ_DONE;
        SQ_DONE: begin
          st_q  <= SQ_IDLE;
          grp_q <= '0;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign st      = st_q;
  assign act_grp = grp_q;
  assign map_err = err_q;

endmodule

// File: rtl/segclk_gate.sv
module segclk_gate
  import segclk_pkg::*;
#(
  parameter int NCHAIN = 3,
  parameter int NSEG   = 3,
  parameter int SW     = 2
) (
  input  logic                      clk,
  input  sq_state_t                 st,
  input  logic [SW-1:0]             act_grp,
  input  logic [NCHAIN*NSEG*SW-1:0] map_flat,
  output logic [NCHAIN*NSEG-1:0]    en
);
  localparam int NTOT = NCHAIN * NSEG;

  logic [NTOT-1:0] raw;
  logic            all_on;

  assign all_on = (st == SQ_LAUNCH) || (st == SQ_CAPTURE);

  for (genvar i = 0; i < NTOT; i++) begin : g_seg
    assign raw[i] = all_on ||
                    ((st == SQ_SHIFT) && (map_flat[i*SW +: SW] == act_grp));

    // Open only during the low phase, so the enable is frozen while clk is high.
    always_latch begin
      if (!clk) en[i] = raw[i];
    end
  end

endmodule

// File: rtl/segclk_ctrl.sv
module segclk_ctrl
  import segclk_pkg::*;
#(
  parameter int NCHAIN = 3,
  parameter int NSEG   = 3,
  parameter int LEN_W  = 16,
  localparam int SW    = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int CW    = (NCHAIN > 1) ? $clog2(NCHAIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LEN_W-1:0]         scan_len,
  input  logic                     cfg_we,
  input  logic [CW-1:0]            cfg_chain,
  input  logic [SW-1:0]            cfg_seg,
  input  logic [SW-1:0]            cfg_grp,
  output logic [NCHAIN*NSEG-1:0]   seg_clk_en,
  output logic [NCHAIN*SW-1:0]     chain_sel,
  output logic                     scan_en,
  output logic                     busy,
  output logic                     done,
  output logic                     map_err
);
  sq_state_t                 st;
  logic [SW-1:0]             act_grp;
  logic [NCHAIN*NSEG*SW-1:0] map_flat;
  logic                      map_ok;
  logic                      start_acc;
  logic                      start_rej;
  logic                      shift_end;
  logic                      in_shift;
  logic                      map_wr;

  assign map_wr   = cfg_we && (st == SQ_IDLE);
  assign in_shift = (st == SQ_SHIFT);

  segclk_map #(.NCHAIN(NCHAIN), .NSEG(NSEG), .SW(SW), .CW(CW)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_wr),
    .wr_chain (cfg_chain),
    .wr_seg   (cfg_seg),
    .wr_grp   (cfg_grp),
    .act_grp  (act_grp),
    .map_flat (map_flat),
    .map_ok   (map_ok),
    .chain_sel(chain_sel)
  );

  segclk_seq #(.NSEG(NSEG), .SW(SW), .LEN_W(LEN_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scan_len (scan_len),
    .map_ok   (map_ok),
    .st       (st),
    .act_grp  (act_grp),
    .start_acc(start_acc),
    .start_rej(start_rej),
    .shift_end(shift_end),
    .map_err  (map_err)
  );

  segclk_gate #(.NCHAIN(NCHAIN), .NSEG(NSEG), .SW(SW)) gate_i (
    .clk     (clk),
    .st      (st),
    .act_grp (act_grp),
    .map_flat(map_flat),
    .en      (seg_clk_en)
  );

  assign scan_en = !((st == SQ_LAUNCH) || (st == SQ_CAPTURE));
  assign busy    = (st != SQ_IDLE);
  assign done    = (st == SQ_DONE);

endmodule

// File: rtl/segclk_ctrl_chk.sv
module segclk_ctrl_chk #(
  parameter int NCHAIN = 3,
  parameter int NSEG   = 3,
  parameter int SW     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [NCHAIN*NSEG-1:0] seg_clk_en,
  input logic                   scan_en,
  input logic                   busy,
  input logic                   done,
  input logic                   map_err,
  input logic                   in_shift,
  input logic                   map_ok,
  input logic                   start_acc,
  input logic                   shift_end,
  input logic [SW-1:0]          act_grp
);
  logic [NCHAIN*NSEG-1:0] en_at_rise;
  logic                   rise_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_at_rise <= '0;
      rise_seen  <= 1'b0;
    end else begin
      en_at_rise <= seg_clk_en;
      rise_seen  <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chk
    a_r3_one_per_chain: assert property (@(posedge clk) disable iff (!rst_n)
      in_shift |-> $countones(seg_clk_en[c*NSEG +: NSEG]) == 1);
  end

  a_r2_group_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && $past(in_shift)) |->
      (act_grp == $past(act_grp) || act_grp == $past(act_grp) + SW'(1)));

  a_r2_first_group: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (in_shift && act_grp == '0));

  a_r4_capture_all: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> &seg_clk_en);

  a_r4_drop_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_end |=> !scan_en);

  a_r4_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> !scan_en);

  a_r4_back_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && $past(!scan_en)) |=> scan_en);

  a_r9_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!scan_en) && scan_en));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !map_ok) |=> (!busy && map_err));

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);

  a_r11_frozen_high: assert property (@(negedge clk) disable iff (!rst_n || !rise_seen)
    seg_clk_en == en_at_rise);

endmodule

bind segclk_ctrl segclk_ctrl_chk #(.NCHAIN(NCHAIN), .NSEG(NSEG), .SW(SW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .seg_clk_en(seg_clk_en),
  .scan_en   (scan_en),
  .busy      (busy),
  .done      (done),
  .map_err   (map_err),
  .in_shift  (in_shift),
  .map_ok    (map_ok),
  .start_acc (start_acc),
  .shift_end (shift_end),
  .act_grp   (act_grp)
);

// File: tb/segclk_ctrl_tb.sv
module segclk_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int NCH = 3;
  localparam int NSG = 3;
  localparam int LW  = 16;
  localparam int SW  = 2;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] scan_len = '0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_chain = '0;
  logic [SW-1:0] cfg_seg = '0;
  logic [SW-1:0] cfg_grp = '0;
  logic [NCH*NSG-1:0] seg_clk_en;
  logic [NCH*SW-1:0] chain_sel;
  logic scan_en, busy, done, map_err;

  segclk_ctrl #(.NCHAIN(NCH), .NSEG(NSG), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_len(scan_len),
    .cfg_we(cfg_we), .cfg_chain(cfg_chain), .cfg_seg(cfg_seg), .cfg_grp(cfg_grp),
    .seg_clk_en(seg_clk_en), .chain_sel(chain_sel), .scan_en(scan_en),
    .busy(busy), .done(done), .map_err(map_err)
  );

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_map [NCH][NSG];
  int m_phase = 0;   // 0 idle, 1 shift, 2 launch, 3 capture, 4 done
  int m_pulse = 0;
  int m_seglen = 1;
  bit m_err = 0;

  function automatic bit m_legal();
    for (int c = 0; c < NCH; c++) begin
      int seen = 0;
      for (int s = 0; s < NSG; s++) begin
        if (m_map[c][s] >= NSG) return 0;
        seen = seen | (1 << m_map[c][s]);
      end
      if (seen != (1 << NSG) - 1) return 0;
    end
    return 1;
  endfunction

  function automatic int m_group();
    if (m_phase == 1) return m_pulse / m_seglen;
    if (m_phase >= 2) return NSG - 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_err = 0; m_pulse = 0;
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < NSG; s++) m_map[c][s] = s;
    end else begin
      case (m_phase)
        0: begin
          if (start) begin
            if (m_legal() && (int'(scan_len) / NSG) > 0) begin
              m_phase = 1; m_pulse = 0; m_seglen = int'(scan_len) / NSG; m_err = 0;
            end else m_err = 1;
          end
          if (cfg_we && int'(cfg_chain) < NCH && int'(cfg_seg) < NSG)
            m_map[cfg_chain][cfg_seg] = int'(cfg_grp);
        end
        1: begin
          m_pulse++;
          if (m_pulse == m_seglen * NSG) m_phase = 2;
        end
        2: m_phase = 3;
        3: m_phase = 4;
        default: m_phase = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison (low phase) ----------------
  logic [NCH*NSG-1:0] en_low;
  bit low_valid = 0;
  int shift_cnt [NCH*NSG];

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < NSG; s++) begin
          bit e;
          e = (m_phase == 1) ? (m_map[c][s] == m_group()) : (m_phase == 2 || m_phase == 3);
          check(seg_clk_en[c*NSG+s] == e, "R3 R5", $sformatf("enable c%0d s%0d", c, s),
                seg_clk_en[c*NSG+s], e);
        end
        if (m_phase != 0) begin
          int es = 0;
          for (int s = NSG - 1; s >= 0; s--) if (m_map[c][s] == m_group()) es = s;
          check(chain_sel[c*SW +: SW] == SW'(es), "R6", $sformatf("select chain %0d", c),
                chain_sel[c*SW +: SW], es);
        end
      end
      check(scan_en == !(m_phase == 2 || m_phase == 3), "R4", "scan_en", scan_en,
            !(m_phase == 2 || m_phase == 3));
      check(busy == (m_phase != 0), "R8", "busy", busy, m_phase != 0);
      check(done == (m_phase == 4), "R9", "done", done, m_phase == 4);
      check(map_err == m_err, "R10", "map_err", map_err, m_err);
      if (busy && scan_en)
        for (int i = 0; i < NCH*NSG; i++) shift_cnt[i] += int'(seg_clk_en[i]);
      en_low = seg_clk_en;
      low_valid = 1;
    end
  end

  // Enables just after a rising edge must still hold the low-phase value.
  always @(posedge clk) begin
    #1;
    if (rst_n && low_valid && !finished)
      check(seg_clk_en == en_low, "R11", "enable moved in high phase", seg_clk_en, en_low);
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic wr_map(input int c, input int s, input int g);
    step();
    cfg_we = 1; cfg_chain = CW'(c); cfg_seg = SW'(s); cfg_grp = SW'(g);
    step();
    cfg_we = 0;
  endtask

  task automatic kick(input int len);
    step();
    for (int i = 0; i < NCH*NSG; i++) shift_cnt[i] = 0;
    scan_len = LW'(len); start = 1;
    step();
    start = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 500) begin step(); k++; end
    check(k < 500, "R9", "done never seen", k, 0);
    step();
  endtask

  task automatic check_counts(input int len);
    for (int i = 0; i < NCH*NSG; i++)
      check(shift_cnt[i] == len / NSG, "R7", $sformatf("shift cycles seg %0d", i),
            shift_cnt[i], len / NSG);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk); #2;
    // R1: reset state
    check(seg_clk_en == '0, "R1", "enables", seg_clk_en, 0);
    check(scan_en == 1'b1, "R1", "scan_en", scan_en, 1);
    check(!busy && !done && !map_err, "R1", "status", {busy, done, map_err}, 0);

    // R2 R7: identity map, L = 6
    kick(6); wait_done(); check_counts(6);

    // R5: non-aligned grouping
    wr_map(0, 0, 2); wr_map(0, 1, 0); wr_map(0, 2, 1);
    wr_map(1, 0, 1); wr_map(1, 1, 2); wr_map(1, 2, 0);
    wr_map(3, 0, 1);            // R5: chain index out of range, ignored
    kick(9);
    repeat (4) step();
    scan_len = 30;              // R7: ignored mid-run
    start = 1; step(); start = 0;   // R8: restart while busy ignored
    cfg_we = 1; cfg_chain = 2; cfg_seg = 0; cfg_grp = 1; step(); cfg_we = 0; // R5: write while busy ignored
    wait_done(); check_counts(9);

    // R10: duplicate group in chain 2
    wr_map(2, 0, 1);
    kick(6);
    repeat (2) step();
    check(!busy && map_err, "R10", "illegal map refused", {busy, map_err}, 1);
    wr_map(2, 0, 0);
    kick(6); wait_done(); check_counts(6);
    check(!map_err, "R10", "map_err cleared", map_err, 0);

    // R10: too short
    kick(2); repeat (2) step();
    check(!busy && map_err, "R10", "short length refused", {busy, map_err}, 1);

    // R7: length not a multiple of the segment count
    kick(4); wait_done(); check_counts(4);
    kick(15); wait_done(); check_counts(15);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule